// File: doc/BRIEF.md
# Hot-Plug Detect Monitor and Interrupt Controller

This block watches the hot-plug detect line of a display source port. A microsecond tick, supplied from outside, is the time base. When the sink appears the block raises a connect event straight away. A low period on the line is measured in ticks. If the line comes back before the disconnect limit, the low period is reported as a pulse and its length is stored in microseconds. If that length falls inside the IRQ window, the pulse is also reported as a sink interrupt request. If the line stays low up to the disconnect limit, the block reports a disconnect instead.

These hot-plug events are merged with strobes from elsewhere in the port. Those strobes are reply received, reply timeout, extended packet sent, audio stream ID mismatch and four vertical-blanking strobes. All events go into one sticky status register. A mask register then gates the sources that may drive the single level-sensitive interrupt line.

A simple register port gives access to four registers:
- status, cleared on read or on any write
- mask, reset to all ones
- raw state, a live view of some levels
- pulse duration

Reads are combinational and take effect in the cycle the read strobe is high. Event and control pins are plain single-cycle strobes and levels. They carry no handshake and are never back-pressured.

Top module: `hpdm_top`

## Requirements
- R1: After reset the status register (address 0) reads 0, the mask register (address 1) reads 0x3FFF, the duration register (address 3) reads 0, and `irq_o` is low.
- R2: A high level on the synchronised hot-plug line while the block considers the sink absent sets status bit 1 (hot-plug event) within a few cycles, with no delay measured in ticks.
- R3: While the sink is present, a low period reaching 2000 ticks sets status bit 1 as a disconnect, and it does so while the line is still low. A low period shorter than that does not set bit 1. A rise after a disconnect sets bit 1 again and sets no pulse bit.
- R4: A low period of 500 to 1000 ticks inclusive, ending before the disconnect limit, sets status bits 0 (IRQ) and 4 (pulse). The duration register (address 3) then holds the tick count of the low period.
- R5: A low period shorter than 500 ticks, or from 1001 up to 1999 ticks, sets status bit 4 but not bit 0, and its tick count is stored in the duration register.
- R6: The external strobes set these status bits:
  - bit 2: reply received
  - bit 3: reply timeout
  - bit 5: extended packet sent
  - bit 9: audio ID mismatch
  - bits 10 to 13: vertical-blanking strobes 0 to 3

  Bits 6 to 8, 14 and 15 always read 0.
- R7: A read of address 0 returns the status and clears it at the end of that cycle. A write to address 0 with any data also clears it.
- R8: An event that arrives in the same cycle as a status clear stays set after the clear.
- R9: `irq_o` is high exactly when some status bit is set whose mask bit is 0. A mask bit set to 1 never stops its status bit from being set.
- R10: Address 2 and `raw_state_o` show live, unlatched levels:
  - bit 0: synchronised hot-plug level
  - bit 1: request active
  - bit 2: reply active
  - bit 3: reply timeout level

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hpd_i | input | 1 | Raw hot-plug detect line |
| tick_i | input | 1 | One-cycle strobe every microsecond |
| reply_rx_evt_i | input | 1 | Reply received strobe |
| reply_tmo_evt_i | input | 1 | Reply timeout strobe |
| ext_pkt_evt_i | input | 1 | Extended packet sent strobe |
| audio_mis_evt_i | input | 1 | Audio stream ID mismatch strobe |
| vblank_evt_i | input | 4 | Vertical-blanking strobes, streams 0 to 3 |
| req_active_i | input | 1 | Request transmission in progress level |
| reply_active_i | input | 1 | Reply reception in progress level |
| reply_tmo_lvl_i | input | 1 | Reply timeout level |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data, valid in the cycle of the read |
| irq_o | output | 1 | Level interrupt |
| raw_state_o | output | 4 | Live state levels |
| hpd_duration_o | output | 16 | Last measured pulse length in ticks |

## Verification
The bench drives low periods at the IRQ window edges: 499, 500, 1000 and 1001 ticks. An off-by-one comparison would report a plain pulse as an IRQ, or the reverse. It holds a 1500-tick low period to show that nothing is disconnected early. It holds a 2100-tick low period and reads the status while the line is still low, which catches a design that waits for the rise to report a disconnect or that wrongly calls it a pulse. It also strobes an event in the same cycle as a status read, which a design with clear priority would lose. Finally it unmasks one source and checks that masked sources still latch, which catches a mask applied to the status instead of the output.

// File: rtl/hpdm_pkg.sv
package hpdm_pkg;
  localparam int ST_W   = 14;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_STATUS = 2'd0;
  localparam logic [ADDR_W-1:0] A_MASK   = 2'd1;
  localparam logic [ADDR_W-1:0] A_RAW    = 2'd2;
  localparam logic [ADDR_W-1:0] A_DUR    = 2'd3;

  // status bit positions
  localparam int B_IRQ   = 0;
  localparam int B_HPD   = 1;
  localparam int B_RRX   = 2;
  localparam int B_RTMO  = 3;
  localparam int B_PULSE = 4;
  localparam int B_EXT   = 5;
  localparam int B_AUD   = 9;
  localparam int B_VB0   = 10;

  localparam logic [ST_W-1:0] ST_VALID = 14'b11_1110_0011_1111;
endpackage

// File: rtl/hpdm_sync.sv
module hpdm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= 1'b0;
        else if (s == 0) chain_q[s] <= d_i;
        else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/hpdm_timer.sv
module hpdm_timer #(
  parameter int DUR_W   = 16,
  parameter int IRQ_MIN = 500,
  parameter int IRQ_MAX = 1000,
  parameter int DISC    = 2000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hpd_s_i,
  input  logic             tick_i,
  output logic             evt_hpd_o,
  output logic             evt_irq_o,
  output logic             evt_pulse_o,
  output logic [DUR_W-1:0] dur_o
);
  localparam logic [DUR_W-1:0] CNT_MAX = {DUR_W{1'b1}};
  localparam logic [DUR_W-1:0] MIN_C   = DUR_W'(IRQ_MIN);
  localparam logic [DUR_W-1:0] MAX_C   = DUR_W'(IRQ_MAX);
  localparam logic [DUR_W-1:0] DISC_C  = DUR_W'(DISC);

  logic             prev_q, present_q;
  logic [DUR_W-1:0] low_cnt_q, dur_q;
  logic             fall, rise, do_conn, do_disc, do_pulse, in_win;

  assign fall     = prev_q & ~hpd_s_i;
  assign rise     = ~prev_q & hpd_s_i;
  assign do_conn  = ~present_q & hpd_s_i;
  assign do_disc  = present_q & ~hpd_s_i & (low_cnt_q >= DISC_C);
  assign do_pulse = present_q & rise & (low_cnt_q < DISC_C);
  assign in_win   = (low_cnt_q >= MIN_C) && (low_cnt_q <= MAX_C);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q    <= 1'b0;
      present_q <= 1'b0;
      low_cnt_q <= '0;
      dur_q     <= '0;
    end else begin
      prev_q <= hpd_s_i;
      if (fall) low_cnt_q <= tick_i ? DUR_W'(1) : '0;
      else if (!hpd_s_i && tick_i && low_cnt_q != CNT_MAX) low_cnt_q <= low_cnt_q + 1'b1;
      if (do_conn) present_q <= 1'b1;
      else if (do_disc) present_q <= 1'b0;
      if (do_pulse) dur_q <= low_cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_hpd_o   <= 1'b0;
      evt_irq_o   <= 1'b0;
      evt_pulse_o <= 1'b0;
    end else begin
      evt_hpd_o   <= do_conn | do_disc | (present_q & rise & ~do_pulse);
      evt_pulse_o <= do_pulse;
      evt_irq_o   <= do_pulse & in_win;
    end
  end

  assign dur_o = dur_q;
endmodule

// File: rtl/hpdm_status.sv
module hpdm_status
  import hpdm_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ST_W-1:0] evt_i,
  input  logic            clr_i,
  input  logic            mask_we_i,
  input  logic [ST_W-1:0] mask_d_i,
  output logic [ST_W-1:0] status_o,
  output logic [ST_W-1:0] mask_o,
  output logic            irq_o
);
  logic [ST_W-1:0] st_q, mask_q;

  generate
    for (genvar b = 0; b < ST_W; b++) begin : g_bit
      if (ST_VALID[b]) begin : g_impl
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) st_q[b] <= 1'b0;
          else st_q[b] <= (st_q[b] & ~clr_i) | evt_i[b];
        end
      end else begin : g_none
        assign st_q[b] = 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '1;
    else if (mask_we_i) mask_q <= mask_d_i;
  end

  assign status_o = st_q;
  assign mask_o   = mask_q;
  assign irq_o    = |(st_q & ~mask_q);
endmodule

// File: rtl/hpdm_top.sv
module hpdm_top
  import hpdm_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DUR_W       = 16,
  parameter int IRQ_MIN_US  = 500,
  parameter int IRQ_MAX_US  = 1000,
  parameter int DISC_US     = 2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hpd_i,
  input  logic              tick_i,
  input  logic              reply_rx_evt_i,
  input  logic              reply_tmo_evt_i,
  input  logic              ext_pkt_evt_i,
  input  logic              audio_mis_evt_i,
  input  logic [3:0]        vblank_evt_i,
  input  logic              req_active_i,
  input  logic              reply_active_i,
  input  logic              reply_tmo_lvl_i,
  input  logic              reg_rd_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              irq_o,
  output logic [3:0]        raw_state_o,
  output logic [DUR_W-1:0]  hpd_duration_o
);
  logic            hpd_s;
  logic            ev_hpd, ev_irq, ev_pulse;
  logic [ST_W-1:0] evt_vec, st_q, mask_q;
  logic            st_clr, mask_we;

  hpdm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(hpd_i), .q_o(hpd_s)
  );

  hpdm_timer #(
    .DUR_W(DUR_W), .IRQ_MIN(IRQ_MIN_US), .IRQ_MAX(IRQ_MAX_US), .DISC(DISC_US)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .hpd_s_i(hpd_s), .tick_i(tick_i),
    .evt_hpd_o(ev_hpd), .evt_irq_o(ev_irq), .evt_pulse_o(ev_pulse),
    .dur_o(hpd_duration_o)
  );

  always_comb begin
    evt_vec              = '0;
    evt_vec[B_IRQ]       = ev_irq;
    evt_vec[B_HPD]       = ev_hpd;
    evt_vec[B_RRX]       = reply_rx_evt_i;
    evt_vec[B_RTMO]      = reply_tmo_evt_i;
    evt_vec[B_PULSE]     = ev_pulse;
    evt_vec[B_EXT]       = ext_pkt_evt_i;
    evt_vec[B_AUD]       = audio_mis_evt_i;
    evt_vec[B_VB0 +: 4]  = vblank_evt_i;
  end

  assign st_clr  = (reg_rd_i | reg_wr_i) && (reg_addr_i == A_STATUS);
  assign mask_we = reg_wr_i && (reg_addr_i == A_MASK);

  hpdm_status u_status (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_vec), .clr_i(st_clr),
    .mask_we_i(mask_we), .mask_d_i(reg_wdata_i[ST_W-1:0]),
    .status_o(st_q), .mask_o(mask_q), .irq_o(irq_o)
  );

  assign raw_state_o = {reply_tmo_lvl_i, reply_active_i, req_active_i, hpd_s};

  always_comb begin
    unique case (reg_addr_i)
      A_STATUS: reg_rdata_o = REG_W'(st_q);
      A_MASK:   reg_rdata_o = REG_W'(mask_q);
      A_RAW:    reg_rdata_o = REG_W'(raw_state_o);
      default:  reg_rdata_o = REG_W'(hpd_duration_o);
    endcase
  end
endmodule

// File: rtl/hpdm_checker.sv
module hpdm_checker
  import hpdm_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              reg_rd,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [ST_W-1:0]   status,
  input logic [ST_W-1:0]   mask,
  input logic [ST_W-1:0]   evt,
  input logic              irq,
  input logic              reply_tmo_evt,
  input logic [3:0]        vblank_evt
);
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == A_STATUS && evt == '0) |=> (status == '0));

  a_r7_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_STATUS && evt == '0) |=> (status == '0));

  a_r8_event_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (evt[B_RRX] && (reg_rd || reg_wr) && reg_addr == A_STATUS) |=> status[B_RRX]);

  a_r6_vblank_sets: assert property (@(posedge clk) disable iff (!rst_n)
    vblank_evt[0] |=> status[B_VB0]);

  a_r9_masked_still_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (reply_tmo_evt && mask[B_RTMO]) |=> status[B_RTMO]);

  a_r9_irq_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status != '0));

  a_r4_irq_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    evt[B_IRQ] |-> evt[B_PULSE]);
endmodule

bind hpdm_top hpdm_checker u_chk (
  .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd_i), .reg_wr(reg_wr_i),
  .reg_addr(reg_addr_i), .status(st_q), .mask(mask_q), .evt(evt_vec),
  .irq(irq_o), .reply_tmo_evt(reply_tmo_evt_i), .vblank_evt(vblank_evt_i)
);

// File: tb/hpdm_top_test.sv
module hpdm_top_test;
  localparam int CLK_P  = 10;
  localparam int TICK_P = 4;

  logic        clk = 0, rst_n = 0, hpd = 0, tick = 0;
  logic        rrx = 0, rtmo = 0, ext = 0, aud = 0;
  logic [3:0]  vb = 0;
  logic        reqa = 0, repa = 0, tmol = 0;
  logic        rd = 0, wr = 0;
  logic [1:0]  addr = 0;
  logic [15:0] wdata = 0, rdata, dur;
  logic        irq;
  logic [3:0]  raw;
  int          n_chk = 0, n_bad = 0;
  logic [15:0] v;

  hpdm_top uut (
    .clk(clk), .rst_n(rst_n), .hpd_i(hpd), .tick_i(tick),
    .reply_rx_evt_i(rrx), .reply_tmo_evt_i(rtmo), .ext_pkt_evt_i(ext),
    .audio_mis_evt_i(aud), .vblank_evt_i(vb), .req_active_i(reqa),
    .reply_active_i(repa), .reply_tmo_lvl_i(tmol), .reg_rd_i(rd),
    .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq), .raw_state_o(raw), .hpd_duration_o(dur)
  );

  always #(CLK_P/2) clk = ~clk;

  initial begin : tickgen
    int c = 0;
    forever begin
      @(negedge clk);
      tick = (c == 0);
      c = (c + 1) % TICK_P;
    end
  end

  task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", req, got, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_reg(logic [1:0] a, output logic [15:0] val);
    @(negedge clk);
    addr = a; rd = 1;
    #1 val = rdata;
    @(negedge clk);
    rd = 0;
  endtask

  task automatic wr_reg(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1;
    @(negedge clk);
    wr = 0;
  endtask

  task automatic low_pulse(int ticks);
    @(negedge clk);
    hpd = 0;
    cyc(ticks * TICK_P);
    hpd = 1;
    cyc(10);
  endtask

  task automatic t_reset;
    rd_reg(0, v); chk("R1 status", v, 16'h0000);
    rd_reg(1, v); chk("R1 mask", v, 16'h3FFF);
    rd_reg(3, v); chk("R1 duration", v, 16'h0000);
    chk("R1 irq", {15'd0, irq}, 16'h0);
  endtask

  task automatic t_connect;
    @(negedge clk); hpd = 1;
    cyc(8);
    rd_reg(0, v); chk("R2 connect event", v, 16'h0002);
    chk("R9 masked source keeps irq low", {15'd0, irq}, 16'h0);
  endtask

  task automatic t_pulse(int ticks, logic [15:0] exp_st, string tag);
    low_pulse(ticks);
    rd_reg(0, v); chk(tag, v, exp_st);
    rd_reg(3, v); chk(tag, v, 16'(ticks));
  endtask

  task automatic t_disconnect;
    @(negedge clk); hpd = 0;
    cyc(2100 * TICK_P);
    rd_reg(0, v); chk("R3 disconnect while low", v, 16'h0002);
    @(negedge clk); hpd = 1;
    cyc(10);
    rd_reg(0, v); chk("R3 reconnect, no pulse", v, 16'h0002);
    rd_reg(3, v); chk("R3 duration untouched", v, 16'd1500);
  endtask

  task automatic t_strobes;
    @(negedge clk); rrx = 1; rtmo = 1; ext = 1; aud = 1; vb = 4'hF;
    @(negedge clk); rrx = 0; rtmo = 0; ext = 0; aud = 0; vb = 0;
    rd_reg(0, v); chk("R6 strobe bit map", v, 16'h3E2C);
    rd_reg(0, v); chk("R7 read cleared", v, 16'h0000);
  endtask

  task automatic t_write_clear;
    @(negedge clk); aud = 1;
    @(negedge clk); aud = 0;
    wr_reg(0, 16'h0000);
    rd_reg(0, v); chk("R7 write clears", v, 16'h0000);
  endtask

  task automatic t_same_cycle;
    @(negedge clk); addr = 0; rd = 1; rrx = 1;
    @(negedge clk); rd = 0; rrx = 0;
    rd_reg(0, v); chk("R8 event kept over clear", v, 16'h0004);
  endtask

  task automatic t_mask;
    wr_reg(1, 16'h3FFB);
    rd_reg(1, v); chk("R9 mask readback", v, 16'h3FFB);
    @(negedge clk); rtmo = 1;
    @(negedge clk); rtmo = 0;
    chk("R9 masked timeout no irq", {15'd0, irq}, 16'h0);
    @(negedge clk); rrx = 1;
    @(negedge clk); rrx = 0;
    chk("R9 unmasked irq", {15'd0, irq}, 16'h1);
    rd_reg(0, v); chk("R9 status unaffected by mask", v, 16'h000C);
    chk("R9 irq drops after clear", {15'd0, irq}, 16'h0);
  endtask

  task automatic t_raw;
    @(negedge clk); reqa = 1; repa = 0; tmol = 1;
    rd_reg(2, v); chk("R10 raw a", v, 16'h000B);
    chk("R10 raw port", {12'd0, raw}, 16'h000B);
    @(negedge clk); reqa = 0; repa = 1; tmol = 0;
    rd_reg(2, v); chk("R10 raw b", v, 16'h0005);
  endtask

  initial begin : watchdog
    #(CLK_P * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1;
    cyc(2);
    t_reset;
    t_connect;
    t_pulse(700,  16'h0011, "R4 irq pulse 700");
    t_pulse(500,  16'h0011, "R4 irq pulse 500");
    t_pulse(1000, 16'h0011, "R4 irq pulse 1000");
    t_pulse(499,  16'h0010, "R5 short pulse 499");
    t_pulse(1001, 16'h0010, "R5 long pulse 1001");
    t_pulse(100,  16'h0010, "R5 short pulse 100");
    t_pulse(1500, 16'h0010, "R3 R5 1500 is no disconnect");
    t_disconnect;
    t_strobes;
    t_write_clear;
    t_same_cycle;
    t_mask;
    t_raw;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule